// File: doc/BRIEF.md
# Microcode Dispatch Sequencer

This block resolves a table-indirect branch for a microcoded control unit. A dispatch request carries several inputs:

- a source word;
- a field specifier, made of a left-rotation count and a field width;
- a base address into an internal dispatch table;
- the address of the dispatch microinstruction itself;
- a flag that chooses which address a call stacks;
- an optional selector for one extra low-order bit, taken from a small set of external status inputs.

The block cuts the field out of the source word and ORs it into the base, together with the extra bit. It reads the addressed table entry and decodes the entry's action into the next microinstruction address.

The decode also produces a kill indication for the microinstruction that follows the dispatch. For delayed variants that instruction runs, and for plain transfers it is dropped. Calls and returns drive an internal return-address stack. The table is loaded through a separate write port. The result appears one clock after the request, and requests may be issued on every cycle.

Top module: `udisp_seq`

## Requirements
- R1: A table entry is 17 bits, with the action in bits [16:14] and the target address in bits [13:0]. An entry written through the write port is what a later dispatch to that index reads. `res_valid` is high exactly in the cycle after a cycle with `disp_valid` high, and `res_next`/`res_kill` belong to that request.
- R2: The table index is formed in three steps. The source word is rotated left by `disp_rot`. Its low `min(disp_width, 11)` bits are kept, and a width of 0 gives an index of 0. The result is ORed bitwise into `disp_base`; it is not added to it.
- R3: `ext_sel` = 0 adds nothing to the index. `ext_sel` = k (1..3) ORs `ext_bits[k-1]` into index bit 0.
- R4: Action 1 (jump) gives `res_next` = target with `res_kill` = 1. Action 2 (delayed jump) gives `res_next` = target with `res_kill` = 0.
- R5: Action 3 (call) gives `res_next` = target with `res_kill` = 1, and with `disp_soa` = 0 it pushes pc+1. Action 4 (delayed call) gives `res_next` = target with `res_kill` = 0, and with `disp_soa` = 0 it pushes pc+2.
- R6: With `disp_soa` = 1, both call actions push the dispatch's own `disp_pc`.
- R7: Action 5 (return) on a non-empty stack gives `res_next` = the most recently pushed address that has not yet been popped, with `res_kill` = 1, and pops that address. The stack holds 8 entries in last-in, first-out order.
- R8: Action 6 (skip) gives `res_next` = pc+2 with `res_kill` = 1. Action 0 and code 7 both give `res_next` = pc+1 with `res_kill` = 0. All address arithmetic wraps modulo 2^14.
- R9: A call made while 8 entries are held still transfers to the target. Its push is dropped, and `ovf_err` rises in the next cycle and stays high until reset.
- R10: A return made on an empty stack gives `res_next` = pc+1 with `res_kill` = 0. `unf_err` rises in the next cycle and stays high until reset.
- R11: A write and a dispatch read of the same index in the same cycle return the old entry. Back-to-back dispatches see the stack effects of all earlier dispatches.
- R12: Synchronous active-low reset leaves `res_valid`, `ovf_err` and `unf_err` low and the stack empty. Table contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_word | input | 32 | Source word holding the index field |
| disp_rot | input | 5 | Left-rotation count |
| disp_width | input | 4 | Field width in bits (capped at 11) |
| disp_base | input | 11 | Dispatch table base address |
| disp_soa | input | 1 | Calls stack the dispatch's own address |
| disp_pc | input | 14 | Address of the dispatch microinstruction |
| ext_sel | input | 2 | Extra-bit source select (0 = none) |
| ext_bits | input | 3 | External status bits for the extra index bit |
| tab_we | input | 1 | Table write enable |
| tab_waddr | input | 11 | Table write index |
| tab_wdata | input | 17 | Table entry {action, target} |
| res_valid | output | 1 | Dispatch result valid |
| res_next | output | 14 | Next microinstruction address |
| res_kill | output | 1 | Drop the instruction following the dispatch |
| ovf_err | output | 1 | Sticky stack overflow |
| unf_err | output | 1 | Sticky stack underflow |

## Verification
A wrong stack pointer or a corrupted stack slot stays hidden until a later return. That return then shows a wrong `res_next` one cycle after its request, or a premature or missing `ovf_err`/`unf_err` one cycle after that. A misformed index shows up as a wrong target in the result cycle of the same dispatch, so the stimulus preloads distinct targets at the OR and sum positions of the same base. The long random stream mixes calls and returns, so that stale stack state reaches the outputs within a few dispatches.

// File: rtl/udisp_pkg.sv
// Shared types for the microcode dispatch sequencer.
// Assumes a 14-bit microinstruction address and a 3-bit action code.
package udisp_pkg;
    localparam int UA_W  = 14;
    localparam int ACT_W = 3;

    typedef enum logic [ACT_W-1:0] {
        ACT_NOP     = 3'd0,
        ACT_JUMP    = 3'd1,
        ACT_JUMP_XN = 3'd2,
        ACT_CALL    = 3'd3,
        ACT_CALL_XN = 3'd4,
        ACT_RETURN  = 3'd5,
        ACT_SKIP    = 3'd6,
        ACT_RSVD    = 3'd7
    } disp_act_e;

    typedef struct packed {
        disp_act_e        act;
        logic [UA_W-1:0]  target;
    } disp_entry_t;
endpackage

// File: rtl/udisp_field.sv
// Field extractor: rotates the source word left and keeps a low field
// whose width is capped at the index width. Purely combinational.
// Assumes DATA_W >= IDX_W.
module udisp_field #(
    parameter int DATA_W = 32,
    parameter int ROT_W  = 5,
    parameter int WID_W  = 4,
    parameter int IDX_W  = 11
) (
    input  logic [DATA_W-1:0] word,
    input  logic [ROT_W-1:0]  rot,
    input  logic [WID_W-1:0]  wid,
    output logic [IDX_W-1:0]  idx
);
    localparam int CAP = IDX_W;

    logic [2*DATA_W-1:0] dbl;
    logic [DATA_W-1:0]   rotl;
    logic [WID_W-1:0]    wid_eff;
    logic [IDX_W-1:0]    mask;

    // Rotate left by shifting a doubled copy and keeping its upper half.
    always_comb begin
        dbl  = {word, word} << rot;
        rotl = dbl[2*DATA_W-1:DATA_W];
    end

    // Clamp the requested width to the index width.
    always_comb begin
        if (int'(wid) > CAP) wid_eff = WID_W'(CAP);
        else                 wid_eff = wid;
    end

    // One mask bit per index position, set below the effective width.
    for (genvar g = 0; g < IDX_W; g++) begin : g_mask
        assign mask[g] = (int'(wid_eff) > g);
    end

    assign idx = rotl[IDX_W-1:0] & mask;
endmodule

// File: rtl/udisp_table.sv
// Dispatch table: single write port, one synchronous read port.
// A read of an index written in the same cycle returns the old entry.
// Contents are not reset; the user loads every entry before use.
module udisp_table #(
    parameter int AW = 11,
    parameter int DW = 17
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store an entry from the write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Register the addressed entry on a read request.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/udisp_stack.sv
// Return-address stack of DEPTH entries. A push when full is dropped
// and sets a sticky overflow flag; a pop when empty sets a sticky
// underflow flag. Push has priority over pop (both never asked at once).
module udisp_stack #(
    parameter int DEPTH = 8,
    parameter int DW    = 14,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    top,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             unf
);
    logic [DW-1:0]    slot [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic             push_ok;
    logic [IX_W-1:0]  top_ix;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign top_ix  = IX_W'(cnt - 1'b1);
    assign top     = slot[top_ix];
    assign count   = cnt;

    // Write the pushed address into the next free slot.
    always_ff @(posedge clk) begin
        if (push_ok) slot[IX_W'(cnt)] <= din;
    end

    // Track occupancy and the sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else if (push) begin
            if (full) ovf <= 1'b1;
            else      cnt <= cnt + 1'b1;
        end else if (pop) begin
            if (empty) unf <= 1'b1;
            else       cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/udisp_seq.sv
// Microcode dispatch sequencer top. Cycle 1: form the table index and
// read the table. Cycle 2: decode the entry into next address and kill,
// and update the return stack at the end of that cycle.
// Assumes one request per cycle at most; results keep request order.
module udisp_seq
    import udisp_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ROT_W     = 5,
    parameter int WID_W     = 4,
    parameter int TAB_AW    = 11,
    parameter int STK_DEPTH = 8,
    parameter int EXT_N     = 3,
    localparam int EXT_SEL_W = $clog2(EXT_N + 1),
    localparam int ENT_W     = $bits(disp_entry_t)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 disp_valid,
    input  logic [DATA_W-1:0]    disp_word,
    input  logic [ROT_W-1:0]     disp_rot,
    input  logic [WID_W-1:0]     disp_width,
    input  logic [TAB_AW-1:0]    disp_base,
    input  logic                 disp_soa,
    input  logic [UA_W-1:0]      disp_pc,
    input  logic [EXT_SEL_W-1:0] ext_sel,
    input  logic [EXT_N-1:0]     ext_bits,
    input  logic                 tab_we,
    input  logic [TAB_AW-1:0]    tab_waddr,
    input  logic [ENT_W-1:0]     tab_wdata,
    output logic                 res_valid,
    output logic [UA_W-1:0]      res_next,
    output logic                 res_kill,
    output logic                 ovf_err,
    output logic                 unf_err
);
    localparam int CNT_W = $clog2(STK_DEPTH + 1);

    logic [TAB_AW-1:0] fld_idx;
    logic              ext_bit;
    logic [TAB_AW-1:0] rd_addr;
    logic [ENT_W-1:0]  rd_data;
    disp_entry_t       ent;

    logic              s2_valid;
    logic [UA_W-1:0]   s2_pc;
    logic              s2_soa;

    logic [UA_W-1:0]   pc_p1, pc_p2;
    logic              stk_push, stk_pop;
    logic [UA_W-1:0]   stk_din, stk_top;
    logic              stk_empty, stk_full;
    logic [CNT_W-1:0]  stk_count;

    udisp_field #(
        .DATA_W(DATA_W), .ROT_W(ROT_W), .WID_W(WID_W), .IDX_W(TAB_AW)
    ) u_field (
        .word(disp_word), .rot(disp_rot), .wid(disp_width), .idx(fld_idx)
    );

    // Pick the optional extra index bit from the selected status input.
    always_comb begin
        ext_bit = 1'b0;
        for (int i = 0; i < EXT_N; i++) begin
            if (int'(ext_sel) == i + 1) ext_bit = ext_bits[i];
        end
    end

    assign rd_addr = disp_base | fld_idx | TAB_AW'(ext_bit);

    udisp_table #(.AW(TAB_AW), .DW(ENT_W)) u_table (
        .clk(clk), .we(tab_we), .waddr(tab_waddr), .wdata(tab_wdata),
        .re(disp_valid), .raddr(rd_addr), .rdata(rd_data)
    );

    // Carry the request's address and flag alongside the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_pc    <= '0;
            s2_soa   <= 1'b0;
        end else begin
            s2_valid <= disp_valid;
            if (disp_valid) begin
                s2_pc  <= disp_pc;
                s2_soa <= disp_soa;
            end
        end
    end

    assign ent   = disp_entry_t'(rd_data);
    assign pc_p1 = s2_pc + UA_W'(1);
    assign pc_p2 = s2_pc + UA_W'(2);

    // Decode the entry into next address, kill and stack requests.
    always_comb begin
        res_next = pc_p1;
        res_kill = 1'b0;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        stk_din  = pc_p1;
        unique case (ent.act)
            ACT_JUMP: begin
                res_next = ent.target;
                res_kill = 1'b1;
            end
            ACT_JUMP_XN: begin
                res_next = ent.target;
            end
            ACT_CALL: begin
                res_next = ent.target;
                res_kill = 1'b1;
                stk_push = s2_valid;
                stk_din  = s2_soa ? s2_pc : pc_p1;
            end
            ACT_CALL_XN: begin
                res_next = ent.target;
                stk_push = s2_valid;
                stk_din  = s2_soa ? s2_pc : pc_p2;
            end
            ACT_RETURN: begin
                stk_pop = s2_valid;
                if (!stk_empty) begin
                    res_next = stk_top;
                    res_kill = 1'b1;
                end
            end
            ACT_SKIP: begin
                res_next = pc_p2;
                res_kill = 1'b1;
            end
            default: begin
                res_next = pc_p1;
            end
        endcase
    end

    udisp_stack #(.DEPTH(STK_DEPTH), .DW(UA_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop),
        .din(stk_din), .top(stk_top), .empty(stk_empty), .full(stk_full),
        .count(stk_count), .ovf(ovf_err), .unf(unf_err)
    );

    assign res_valid = s2_valid;
endmodule

// File: rtl/udisp_seq_chk.sv
// Property checker for udisp_seq, attached by bind below.
// Observes top-level ports and the stack occupancy count.
module udisp_seq_chk #(
    parameter int STK_DEPTH = 8,
    parameter int CNT_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             disp_valid,
    input logic             res_valid,
    input logic             ovf_err,
    input logic             unf_err,
    input logic [CNT_W-1:0] stk_count
);
    a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> res_valid);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_valid |=> !res_valid);

    a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(stk_count) <= STK_DEPTH);

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    a_r9_ovf_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_err) |-> (int'($past(stk_count)) == STK_DEPTH && $past(res_valid)));

    a_r10_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unf_err |=> unf_err);

    a_r10_unf_only_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf_err) |-> ($past(stk_count) == '0 && $past(res_valid)));

    a_r12_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !ovf_err && !unf_err && stk_count == '0));
endmodule

bind udisp_seq udisp_seq_chk #(
    .STK_DEPTH(STK_DEPTH),
    .CNT_W($clog2(STK_DEPTH + 1))
) u_chk (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .res_valid(res_valid),
    .ovf_err(ovf_err), .unf_err(unf_err), .stk_count(stk_count)
);

// File: tb/tb_udisp_seq.sv
// Self-checking bench: fills the table, runs directed corner cases,
// then a seeded random stream, all against a reference model.
module tb_udisp_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TAB_N      = 2048;
    localparam int STK_N      = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        disp_valid;
    logic [31:0] disp_word;
    logic [4:0]  disp_rot;
    logic [3:0]  disp_width;
    logic [10:0] disp_base;
    logic        disp_soa;
    logic [13:0] disp_pc;
    logic [1:0]  ext_sel;
    logic [2:0]  ext_bits;
    logic        tab_we;
    logic [10:0] tab_waddr;
    logic [16:0] tab_wdata;
    logic        res_valid;
    logic [13:0] res_next;
    logic        res_kill;
    logic        ovf_err;
    logic        unf_err;

    udisp_seq dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [16:0] mmem [TAB_N];
    logic [13:0] mstk [$];
    bit          m_ovf, m_unf;

    bit          p_v;
    logic [13:0] p_next;
    bit          p_kill;
    bit          p_ovf, p_unf;
    string       p_req;

    function automatic logic [16:0] ent(input logic [2:0] a, input logic [13:0] t);
        return {a, t};
    endfunction

    // Reference index: bitwise rotate, clamp width, OR base and extra bit.
    function automatic logic [10:0] m_addr(input logic [31:0] w, input logic [4:0] r,
            input logic [3:0] wd, input logic [10:0] b, input logic [1:0] es, input logic [2:0] eb);
        logic [31:0] rw;
        logic [10:0] ix;
        int n;
        for (int i = 0; i < 32; i++) rw[(i + int'(r)) % 32] = w[i];
        n = (int'(wd) > 11) ? 11 : int'(wd);
        ix = '0;
        for (int i = 0; i < n; i++) ix[i] = rw[i];
        ix = ix | b;
        if (es != 2'd0) ix[0] = ix[0] | eb[int'(es) - 1];
        return ix;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_pending();
        chk({p_req, " valid"}, 32'(res_valid), 32'(p_v));
        if (p_v) begin
            chk({p_req, " next"}, 32'(res_next), 32'(p_next));
            chk({p_req, " kill"}, 32'(res_kill), 32'(p_kill));
        end
        chk("R9 ovf_err", 32'(ovf_err), 32'(p_ovf));
        chk("R10 unf_err", 32'(unf_err), 32'(p_unf));
    endtask

    // One cycle: check the previous result, drive new inputs, update the model.
    task automatic cyc(input bit v, input logic [31:0] w, input logic [4:0] r, input logic [3:0] wd,
            input logic [10:0] b, input bit soa, input logic [13:0] pc, input logic [1:0] es,
            input logic [2:0] eb, input bit we, input logic [10:0] wa, input logic [16:0] wdat);
        logic [10:0] a;
        logic [16:0] e;
        logic [13:0] t;
        @(negedge clk);
        check_pending();
        disp_valid = v; disp_word = w; disp_rot = r; disp_width = wd; disp_base = b;
        disp_soa = soa; disp_pc = pc; ext_sel = es; ext_bits = eb;
        tab_we = we; tab_waddr = wa; tab_wdata = wdat;
        p_v = v; p_ovf = m_ovf; p_unf = m_unf;
        if (v) begin
            a = m_addr(w, r, wd, b, es, eb);
            e = mmem[a];
            t = e[13:0];
            p_kill = 1'b0;
            p_next = 14'(pc + 1);
            case (e[16:14])
                3'd1: begin p_next = t; p_kill = 1'b1; p_req = "R1 R2 R3 R4 jump"; end
                3'd2: begin p_next = t; p_req = "R1 R2 R3 R4 delayed jump"; end
                3'd3, 3'd4: begin
                    p_next = t;
                    p_kill = (e[16:14] == 3'd3);
                    p_req = soa ? "R5 R6 call own-address" : "R1 R2 R3 R5 call";
                    if (mstk.size() == STK_N) begin
                        m_ovf = 1'b1;
                        p_req = {p_req, " R9 overflow"};
                    end else if (soa) mstk.push_back(pc);
                    else mstk.push_back(14'(pc + ((e[16:14] == 3'd3) ? 1 : 2)));
                end
                3'd5: begin
                    if (mstk.size() == 0) begin
                        m_unf = 1'b1;
                        p_req = "R10 return underflow";
                    end else begin
                        p_next = mstk.pop_back();
                        p_kill = 1'b1;
                        p_req = "R7 return";
                    end
                end
                3'd6: begin p_next = 14'(pc + 2); p_kill = 1'b1; p_req = "R8 skip"; end
                default: p_req = "R8 sequential";
            endcase
        end else begin
            p_req = "R1 idle";
        end
        if (we) mmem[wa] = wdat;
    endtask

    task automatic dsp(input logic [31:0] w, input logic [4:0] r, input logic [3:0] wd,
            input logic [10:0] b, input bit soa, input logic [13:0] pc,
            input logic [1:0] es, input logic [2:0] eb);
        cyc(1'b1, w, r, wd, b, soa, pc, es, eb, 1'b0, '0, '0);
    endtask

    task automatic wr(input logic [10:0] a, input logic [16:0] d);
        cyc(1'b0, '0, '0, '0, '0, 1'b0, '0, '0, '0, 1'b1, a, d);
    endtask

    // Watchdog: a hung run is one failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240831));
        rst_n = 1'b0;
        disp_valid = 0; disp_word = 0; disp_rot = 0; disp_width = 0; disp_base = 0;
        disp_soa = 0; disp_pc = 0; ext_sel = 0; ext_bits = 0;
        tab_we = 0; tab_waddr = 0; tab_wdata = 0;
        p_v = 0; p_ovf = 0; p_unf = 0; p_req = "R12 reset";
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: outputs cleared in reset
        chk("R12 res_valid", 32'(res_valid), 0);
        chk("R12 ovf_err", 32'(ovf_err), 0);
        chk("R12 unf_err", 32'(unf_err), 0);
        rst_n = 1'b1;

        // R1: load every table entry
        for (int i = 0; i < TAB_N; i++) wr(11'(i), 17'($urandom));

        wr(11'h010, ent(3'd5, 14'h0));
        wr(11'h020, ent(3'd3, 14'h0900));
        wr(11'h021, ent(3'd4, 14'h0A00));
        wr(11'h100, ent(3'd1, 14'h1234));
        wr(11'h101, ent(3'd2, 14'h2345));
        wr(11'h030, ent(3'd6, 14'h1111));
        wr(11'h031, ent(3'd0, 14'h2222));
        wr(11'h032, ent(3'd7, 14'h3333));
        wr(11'h207, ent(3'd1, 14'h0777));
        wr(11'h208, ent(3'd1, 14'h0888));
        wr(11'h200, ent(3'd1, 14'h0BBB));
        wr(11'h20F, ent(3'd1, 14'h0AAA));
        wr(11'h300, ent(3'd1, 14'h0300));
        wr(11'h301, ent(3'd1, 14'h0301));
        wr(11'h400, ent(3'd1, 14'h0111));
        wr(11'h7FF, ent(3'd2, 14'h17FF));

        // R10: return on empty stack
        dsp(0, 0, 0, 11'h010, 0, 14'h0050, 0, 0);
        // R5/R6: calls with and without own-address, then R7 LIFO returns
        dsp(0, 0, 0, 11'h020, 0, 14'h0040, 0, 0);
        dsp(0, 0, 0, 11'h021, 0, 14'h0060, 0, 0);
        dsp(0, 0, 0, 11'h020, 1, 14'h0070, 0, 0);
        dsp(0, 0, 0, 11'h021, 1, 14'h0080, 0, 0);
        for (int i = 0; i < 4; i++) dsp(0, 0, 0, 11'h010, 0, 14'h0100, 0, 0);
        // R9: nine calls overflow, then eight returns
        for (int i = 0; i < 9; i++) dsp(0, 0, 0, 11'h020, 0, 14'(16'h0200 + i), 0, 0);
        for (int i = 0; i < 8; i++) dsp(0, 0, 0, 11'h010, 0, 14'h0300, 0, 0);
        // R4: jumps
        dsp(0, 0, 0, 11'h100, 0, 14'h0010, 0, 0);
        dsp(0, 0, 0, 11'h101, 0, 14'h0011, 0, 0);
        // R8: skip, nop, reserved, and address wrap
        dsp(0, 0, 0, 11'h030, 0, 14'h0020, 0, 0);
        dsp(0, 0, 0, 11'h031, 0, 14'h0021, 0, 0);
        dsp(0, 0, 0, 11'h032, 0, 14'h0022, 0, 0);
        dsp(0, 0, 0, 11'h030, 0, 14'h3FFF, 0, 0);
        // R2: OR not add, rotated field, width clamp
        dsp(32'h5, 0, 4'd3, 11'h203, 0, 14'h0001, 0, 0);
        dsp(32'h0000_0F00, 5'd24, 4'd4, 11'h200, 0, 14'h0002, 0, 0);
        dsp(32'hFFFF_FFFF, 0, 4'd15, 11'h000, 0, 14'h0003, 0, 0);
        dsp(32'hFFFF_FFFF, 5'd7, 4'd0, 11'h200, 0, 14'h0004, 0, 0);
        // R3: extra bit selection
        dsp(0, 0, 0, 11'h300, 0, 14'h0005, 2'd2, 3'b010);
        dsp(0, 0, 0, 11'h300, 0, 14'h0006, 2'd0, 3'b111);
        dsp(0, 0, 0, 11'h300, 0, 14'h0007, 2'd1, 3'b110);
        dsp(0, 0, 0, 11'h300, 0, 14'h0008, 2'd3, 3'b100);
        // R11: same-cycle write and read returns the old entry
        cyc(1'b1, 0, 0, 0, 11'h400, 0, 14'h0009, 0, 0, 1'b1, 11'h400, ent(3'd1, 14'h0222));
        dsp(0, 0, 0, 11'h400, 0, 14'h000A, 0, 0);

        // Random stream with interleaved table writes
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 5) != 0, $urandom, 5'($urandom), 4'($urandom), 11'($urandom),
                1'($urandom), 14'($urandom), 2'($urandom), 3'($urandom),
                ($urandom % 4) == 0, 11'($urandom), 17'($urandom));
        end
        cyc(1'b0, '0, '0, '0, '0, 1'b0, '0, '0, '0, 1'b0, '0, '0);
        @(negedge clk);
        check_pending();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule